// File: doc/BRIEF.md
# Interlocked Frame Receive Gate

This block sits on the receive side of a serial storage link, between the link/transport logic and the host bus. It takes frames as a stream of 32-bit words, each beat carrying start, end and error flags. For frame types configured as interlocked, it keeps the link's final handshake (positive or negative) back until host software has looked at the frame and given a verdict. Frame types not configured that way are acknowledged as soon as they end.

For an interlocked frame the block raises a sticky interrupt status bit at the frame's first word. It copies the first seven words into host-readable capture registers and keeps receiving into a local word buffer, so the link never stalls. Software then picks one of two paths. It can arm forwarding, which streams the whole frame, header included, out of a DMA-side valid/ready port. Or, for short frames, it can read the capture registers directly. After the frame ends, a "frame good" or "frame bad" status bit is set. A good frame waits for an accept or reject pulse. A bad frame is refused at once.

A verdict written before the frame completes takes effect at the frame's last word. All accept, reject and arm controls are single-cycle write-one pulses. Status bits are cleared by writing one to them.

Top module: `ilk_rx_gate`

## Requirements
- R1: Only a frame whose `cfg_mode` (sampled on the start beat) equals binary 10 is interlocked. With any other value, the block issues the handshake on the cycle after the end beat without waiting for a verdict: `ack_ok` if no beat had `rx_err` set, `ack_err` otherwise. It raises no status bit.
- R2: The start beat of an interlocked frame sets `stat_intr` on the next cycle. It stays set until the host pulses `host_clr[0]`.
- R3: Words 0 to 6 of an interlocked frame are stored in capture entries 0 to 6. `cap_rdata` shows the entry chosen by `cap_sel` one cycle after `cap_sel` is set. A `cap_sel` of 7 reads zero, and words after the seventh do not change any entry.
- R4: The receive stream has no back-pressure. Words of an interlocked frame go into a buffer of `FIFO_DEPTH` words. A word that arrives while the buffer is full is dropped and marks the frame as errored.
- R5: After `host_arm` is pulsed during an interlocked frame or while it waits for a verdict, every buffered word of that frame, in arrival order, leaves on `dma_data` under `dma_valid`/`dma_ready`. The frame's last word is marked by `dma_last`. The port holds its word while `dma_ready` is low. Draining continues after the handshake until the buffer is empty.
- R6: At the end beat of an interlocked frame the block sets `stat_ok` (cleared by `host_clr[1]`) if the frame had no error. Otherwise it sets `stat_err` (cleared by `host_clr[2]`).
- R7: An error-free interlocked frame with no verdict yet waits with both handshake outputs low. A later `host_accept` gives a one-cycle `ack_ok` on the next cycle. A later `host_reject` gives a one-cycle `ack_err`.
- R8: An accept or reject pulsed between the start beat and the end beat is kept. The handshake for a good frame then comes on the cycle after the end beat.
- R9: An errored interlocked frame gets `ack_err` on the cycle after its end beat, even if accept was pulsed.
- R10: When accept and reject are pulsed together, reject wins.
- R11: After the handshake the block is idle. Verdict or arm pulses given then produce no handshake and no DMA output. A frame that was not armed has its buffered words discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Handling mode for the frame starting now; 2'b10 selects interlock |
| rx_valid | input | 1 | Receive word present |
| rx_sof | input | 1 | Receive word is the frame's first |
| rx_eof | input | 1 | Receive word is the frame's last |
| rx_err | input | 1 | Link detected an error on this word |
| rx_data | input | DW | Receive word |
| host_arm | input | 1 | Pulse: forward the frame on the DMA port |
| host_accept | input | 1 | Pulse: accept the frame |
| host_reject | input | 1 | Pulse: reject the frame |
| host_clr | input | 3 | Write-one-to-clear for {err, ok, intr} status |
| cap_sel | input | $clog2(CAP_N+1) | Capture entry to read |
| cap_rdata | output | DW | Selected capture entry, registered |
| stat_intr | output | 1 | Interlocked frame arrived (interrupt) |
| stat_ok | output | 1 | Interlocked frame ended with no error |
| stat_err | output | 1 | Interlocked frame ended with an error |
| dma_valid | output | 1 | Forwarded word present |
| dma_data | output | DW | Forwarded word |
| dma_last | output | 1 | Forwarded word is the frame's last |
| dma_ready | input | 1 | DMA side takes the word |
| ack_ok | output | 1 | One-cycle positive handshake request |
| ack_err | output | 1 | One-cycle negative handshake request |

## Verification
The assertions assume that `rx_sof` and `rx_eof` only qualify beats with `rx_valid` high. They also assume that `cfg_mode` is stable from a frame's start beat, and that a new start beat only arrives once the previous handshake has gone out. The stimulus sends whole frames from one task that sets the flags only on valid beats, holds `cfg_mode` for the whole frame, and waits for each handshake before starting another frame. Host pulses are always single cycles, and `dma_ready` is only changed between clock edges.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RECV_I = 2'd1,
    ST_RECV_B = 2'd2,
    ST_WAIT   = 2'd3
  } ilk_state_e;

  localparam logic [1:0] MODE_INTERLOCK = 2'b10;

  localparam int ST_BITS = 3;
  localparam int SB_INTR = 0;
  localparam int SB_OK   = 1;
  localparam int SB_ERR  = 2;

endpackage

// File: rtl/ilk_capture.sv
module ilk_capture #(
  parameter int DW = 32,
  parameter int N  = 7,
  localparam int IW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] sel,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] cap_q [N];

  for (genvar i = 0; i < N; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        cap_q[i] <= '0;
      end else if (we && widx == IW'(i)) begin
        cap_q[i] <= wdata;
      end
    end

    // R3
    entry_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(we && widx == IW'(i)) |=> $stable(cap_q[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (sel < IW'(N)) begin
      rdata <= cap_q[sel];
    end else begin
      rdata <= '0;
    end
  end

endmodule

// File: rtl/ilk_fifo.sv
module ilk_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_last,
  input  logic          arm,
  output logic          full,
  output logic          empty,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  input  logic          out_ready
);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          wr_en, load;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_en = push && !full && !flush;
  assign load  = arm && !empty && !flush && (!out_valid || out_ready);

  // storage: plain write port, registered read port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wp_q] <= {push_last, push_data};
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      {out_last, out_data} <= mem[rp_q];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp_q      <= '0;
      rp_q      <= '0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr_en) wp_q <= ptr_inc(wp_q);
      if (load)  rp_q <= ptr_inc(rp_q);
      cnt_q <= cnt_q + CW'(wr_en) - CW'(load);
      if (load) begin
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));

  // R5
  dma_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

// File: rtl/ilk_status.sv
module ilk_status #(
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set,
  input  logic [NB-1:0] clr,
  output logic [NB-1:0] stat
);

  for (genvar b = 0; b < NB; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stat[b] <= 1'b0;
      end else if (set[b]) begin
        stat[b] <= 1'b1;
      end else if (clr[b]) begin
        stat[b] <= 1'b0;
      end
    end

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (stat[b] && !clr[b]) |=> stat[b]);
  end

endmodule

// File: rtl/ilk_seq.sv
module ilk_seq
  import ilk_pkg::*;
#(
  parameter int N  = 7,
  localparam int IW = $clog2(N + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cfg_mode,
  input  logic               rx_valid,
  input  logic               rx_sof,
  input  logic               rx_eof,
  input  logic               rx_err,
  input  logic               host_arm,
  input  logic               host_accept,
  input  logic               host_reject,
  input  logic               fifo_full,
  input  logic               fifo_empty,
  input  logic               dma_busy,
  output logic               push,
  output logic               cap_we,
  output logic [IW-1:0]      widx,
  output logic               flush,
  output logic               armed,
  output logic [ST_BITS-1:0] set_bits,
  output logic               ack_ok,
  output logic               ack_err
);

  ilk_state_e state_q, state_d;
  logic [IW-1:0] idx_q;
  logic err_q, acc_q, rej_q;
  logic start, ilk_start, in_ilk, in_byp, live, arm_ok;
  logic err_now, err_seen, acc_any, rej_any;
  logic fire_ok, fire_err, fire, set_ok, set_err;

  always_comb begin
    start     = rx_valid && rx_sof && (state_q == ST_IDLE);
    ilk_start = start && (cfg_mode == MODE_INTERLOCK);
    in_ilk    = ilk_start || (state_q == ST_RECV_I);
    in_byp    = (start && !ilk_start) || (state_q == ST_RECV_B);
    live      = start || (state_q != ST_IDLE);
    arm_ok    = in_ilk || (state_q == ST_WAIT);
    push      = rx_valid && in_ilk;
    err_now   = (rx_valid && rx_err) || (push && fifo_full);
    err_seen  = (start ? 1'b0 : err_q) || err_now;
    acc_any   = acc_q || host_accept;
    rej_any   = rej_q || host_reject;
    widx      = start ? '0 : idx_q;
    cap_we    = push && (widx < IW'(N));
  end

  always_comb begin
    state_d  = state_q;
    fire_ok  = 1'b0;
    fire_err = 1'b0;
    set_ok   = 1'b0;
    set_err  = 1'b0;
    if (state_q == ST_WAIT) begin
      if (host_reject) begin
        fire_err = 1'b1;
        state_d  = ST_IDLE;
      end else if (host_accept) begin
        fire_ok = 1'b1;
        state_d = ST_IDLE;
      end
    end else if (push && rx_eof) begin
      state_d = ST_IDLE;
      if (err_seen) begin
        set_err  = 1'b1;
        fire_err = 1'b1;
      end else begin
        set_ok = 1'b1;
        if (rej_any) begin
          fire_err = 1'b1;
        end else if (acc_any) begin
          fire_ok = 1'b1;
        end else begin
          state_d = ST_WAIT;
        end
      end
    end else if (in_byp && rx_valid && rx_eof) begin
      state_d  = ST_IDLE;
      fire_ok  = !err_seen;
      fire_err = err_seen;
    end else if (ilk_start) begin
      state_d = ST_RECV_I;
    end else if (start) begin
      state_d = ST_RECV_B;
    end
  end

  assign fire     = fire_ok || fire_err;
  assign flush    = fire && !armed && !(host_arm && arm_ok);
  assign set_bits = {set_err, set_ok, ilk_start};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      err_q   <= 1'b0;
      acc_q   <= 1'b0;
      rej_q   <= 1'b0;
      armed   <= 1'b0;
      ack_ok  <= 1'b0;
      ack_err <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_ok  <= fire_ok;
      ack_err <= fire_err;
      if (cap_we) idx_q <= widx + 1'b1;
      if (fire || !live) begin
        err_q <= 1'b0;
        acc_q <= 1'b0;
        rej_q <= 1'b0;
      end else begin
        err_q <= err_seen;
        acc_q <= acc_any;
        rej_q <= rej_any;
      end
      if (host_arm && arm_ok) begin
        armed <= 1'b1;
      end else if (!live && fifo_empty && !dma_busy) begin
        armed <= 1'b0;
      end
    end
  end

  // R7
  ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ack_ok && ack_err));

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !host_accept && !host_reject) |=> (!ack_ok && !ack_err));

  // R9
  err_nak_chk: assert property (@(posedge clk) disable iff (rst)
    (push && rx_eof && err_seen) |=> (ack_err && !ack_ok));

  // R11
  idle_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_ok || ack_err) |-> (state_q == ST_IDLE));

endmodule

// File: rtl/ilk_rx_gate.sv
module ilk_rx_gate
  import ilk_pkg::*;
#(
  parameter int DW         = 32,
  parameter int CAP_N      = 7,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 cfg_mode,
  input  logic                       rx_valid,
  input  logic                       rx_sof,
  input  logic                       rx_eof,
  input  logic                       rx_err,
  input  logic [DW-1:0]              rx_data,
  input  logic                       host_arm,
  input  logic                       host_accept,
  input  logic                       host_reject,
  input  logic [2:0]                 host_clr,
  input  logic [$clog2(CAP_N+1)-1:0] cap_sel,
  output logic [DW-1:0]              cap_rdata,
  output logic                       stat_intr,
  output logic                       stat_ok,
  output logic                       stat_err,
  output logic                       dma_valid,
  output logic [DW-1:0]              dma_data,
  output logic                       dma_last,
  input  logic                       dma_ready,
  output logic                       ack_ok,
  output logic                       ack_err
);

  localparam int IW = $clog2(CAP_N + 1);

  logic               push, cap_we, flush, armed, fifo_full, fifo_empty;
  logic [IW-1:0]      widx;
  logic [ST_BITS-1:0] set_bits, stat_bits;

  ilk_seq #(.N(CAP_N)) u_seq (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .host_arm(host_arm), .host_accept(host_accept), .host_reject(host_reject),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .dma_busy(dma_valid),
    .push(push), .cap_we(cap_we), .widx(widx), .flush(flush), .armed(armed),
    .set_bits(set_bits), .ack_ok(ack_ok), .ack_err(ack_err)
  );

  ilk_capture #(.DW(DW), .N(CAP_N)) u_cap (
    .clk(clk), .rst(rst), .we(cap_we), .widx(widx), .wdata(rx_data),
    .sel(cap_sel), .rdata(cap_rdata)
  );

  ilk_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .push_data(rx_data),
    .push_last(rx_eof), .arm(armed), .full(fifo_full), .empty(fifo_empty),
    .out_valid(dma_valid), .out_data(dma_data), .out_last(dma_last),
    .out_ready(dma_ready)
  );

  ilk_status #(.NB(ST_BITS)) u_stat (
    .clk(clk), .rst(rst), .set(set_bits), .clr(host_clr), .stat(stat_bits)
  );

  assign stat_intr = stat_bits[SB_INTR];
  assign stat_ok   = stat_bits[SB_OK];
  assign stat_err  = stat_bits[SB_ERR];

endmodule

// File: tb/ilk_rx_gate_test.sv
`timescale 1ns/1ps
module ilk_rx_gate_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cfg_mode;
  logic        rx_valid, rx_sof, rx_eof, rx_err;
  logic [31:0] rx_data;
  logic        host_arm, host_accept, host_reject;
  logic [2:0]  host_clr;
  logic [2:0]  cap_sel;
  logic [31:0] cap_rdata, dma_data;
  logic        stat_intr, stat_ok, stat_err, dma_valid, dma_last, dma_ready;
  logic        ack_ok, ack_err;

  int checks = 0, fails = 0;
  logic got_ok, got_err;
  logic [31:0] dq [64];
  logic        dl [64];
  int          dn = 0;

  always #2 clk = ~clk;

  ilk_rx_gate uut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err), .rx_data(rx_data),
    .host_arm(host_arm), .host_accept(host_accept), .host_reject(host_reject),
    .host_clr(host_clr), .cap_sel(cap_sel), .cap_rdata(cap_rdata),
    .stat_intr(stat_intr), .stat_ok(stat_ok), .stat_err(stat_err),
    .dma_valid(dma_valid), .dma_data(dma_data), .dma_last(dma_last),
    .dma_ready(dma_ready), .ack_ok(ack_ok), .ack_err(ack_err)
  );

  // DMA collector, sampled between edges
  always @(negedge clk) begin
    if (!rst && dma_valid && dma_ready && dn < 64) begin
      dq[dn] = dma_data;
      dl[dn] = dma_last;
      dn++;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int mode, input int len, input int errb,
                            input int early, input bit arm, input logic [31:0] base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      cfg_mode    = mode[1:0];
      rx_valid    = 1'b1;
      rx_sof      = (i == 0);
      rx_eof      = (i == len - 1);
      rx_err      = (i + 1 == errb);
      rx_data     = base + 32'(i);
      host_accept = (early == 1 && i == 0) || (early == 3 && i == 0);
      host_reject = (early == 2 && i == 0) || (early == 3 && i == 0);
      host_arm    = arm && (i == 0);
    end
    @(negedge clk);
    got_ok = ack_ok;
    got_err = ack_err;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    host_accept = 1'b0; host_reject = 1'b0; host_arm = 1'b0;
  endtask

  task automatic pulse_verdict(input bit acc, input bit rej);
    host_accept = acc;
    host_reject = rej;
    @(negedge clk);
    got_ok = ack_ok;
    got_err = ack_err;
    host_accept = 1'b0;
    host_reject = 1'b0;
  endtask

  task automatic clear_status();
    host_clr = 3'b111;
    @(negedge clk);
    host_clr = 3'b000;
  endtask

  // scenario table: mode, length, error beat (1-based, 0 none),
  // early verdict (0 none, 1 accept, 2 reject), late verdict, expected ack (1 ok, 2 err)
  localparam int NV = 8;
  localparam int V_MODE  [NV] = '{2, 2, 2, 2, 1, 3, 2, 0};
  localparam int V_LEN   [NV] = '{4, 4, 3, 5, 4, 2, 1, 1};
  localparam int V_ERRB  [NV] = '{0, 0, 0, 3, 0, 2, 0, 0};
  localparam int V_EARLY [NV] = '{0, 0, 1, 1, 0, 0, 2, 0};
  localparam int V_LATE  [NV] = '{1, 2, 0, 0, 0, 0, 0, 0};
  localparam int V_EXP   [NV] = '{1, 2, 1, 2, 1, 2, 2, 1};

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_mode = 2'b00; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    rx_err = 1'b0; rx_data = '0; host_arm = 1'b0; host_accept = 1'b0;
    host_reject = 1'b0; host_clr = 3'b000; cap_sel = 3'd0; dma_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk(!ack_ok && !ack_err, "R7 reset ack", {30'd0, ack_ok, ack_err}, 0);
    chk(!stat_intr && !stat_ok && !stat_err, "R2 reset status",
        {29'd0, stat_err, stat_ok, stat_intr}, 0);
    chk(!dma_valid, "R5 reset dma_valid", {31'd0, dma_valid}, 0);
    chk(cap_rdata == 32'd0, "R3 reset capture", cap_rdata, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      send_frame(V_MODE[v], V_LEN[v], V_ERRB[v], V_EARLY[v], 1'b0, 32'h1000_0000 + 32'(v << 8));
      if (V_LATE[v] == 0) begin
        // R1 R8 R9: handshake on cycle after end beat
        chk(got_ok == (V_EXP[v] == 1) && got_err == (V_EXP[v] == 2),
            $sformatf("R8 R9 R1 row %0d ack at end", v), {30'd0, got_ok, got_err},
            (V_EXP[v] == 1) ? 32'd2 : 32'd1);
      end else begin
        chk(!got_ok && !got_err, $sformatf("R7 row %0d waits", v),
            {30'd0, got_ok, got_err}, 0);
        repeat (3) @(negedge clk);
        chk(!ack_ok && !ack_err, $sformatf("R7 row %0d still waits", v),
            {30'd0, ack_ok, ack_err}, 0);
        pulse_verdict(V_LATE[v] == 1, V_LATE[v] == 2);
        chk(got_ok == (V_EXP[v] == 1) && got_err == (V_EXP[v] == 2),
            $sformatf("R7 row %0d late verdict", v), {30'd0, got_ok, got_err},
            (V_EXP[v] == 1) ? 32'd2 : 32'd1);
      end
      chk(stat_intr == (V_MODE[v] == 2), $sformatf("R1 R2 row %0d intr", v),
          {31'd0, stat_intr}, {31'd0, V_MODE[v] == 2});
      if (V_MODE[v] == 2) begin
        chk(stat_ok == (V_ERRB[v] == 0) && stat_err == (V_ERRB[v] != 0),
            $sformatf("R6 row %0d ok/err", v), {30'd0, stat_ok, stat_err},
            (V_ERRB[v] == 0) ? 32'd2 : 32'd1);
      end else begin
        chk(!stat_ok && !stat_err, $sformatf("R1 row %0d no status", v),
            {30'd0, stat_ok, stat_err}, 0);
      end
      clear_status();
      chk(!stat_intr && !stat_ok && !stat_err, $sformatf("R2 R6 row %0d cleared", v),
          {29'd0, stat_err, stat_ok, stat_intr}, 0);
    end

    // R3: capture of a 9-word frame, direct register path
    send_frame(2, 9, 0, 0, 1'b0, 32'hC0DE_0000);
    for (int s = 0; s < 8; s++) begin
      cap_sel = 3'(s);
      @(negedge clk);
      chk(cap_rdata == ((s < 7) ? 32'hC0DE_0000 + 32'(s) : 32'd0),
          $sformatf("R3 capture entry %0d", s), cap_rdata,
          (s < 7) ? 32'hC0DE_0000 + 32'(s) : 32'd0);
    end
    cap_sel = 3'd0;
    chk(!dma_valid, "R5 no forwarding without arm", {31'd0, dma_valid}, 0);
    pulse_verdict(1'b1, 1'b0);
    chk(got_ok && !got_err, "R7 accept after register read", {30'd0, got_ok, got_err}, 2);

    // R2: clearing only the interrupt bit leaves the ok bit
    host_clr = 3'b001;
    @(negedge clk);
    host_clr = 3'b000;
    chk(!stat_intr && stat_ok, "R2 intr clear only", {30'd0, stat_intr, stat_ok}, 1);
    clear_status();

    // R5: armed forwarding with early accept, ready toggling
    dn = 0;
    dma_ready = 1'b0;
    send_frame(2, 5, 0, 1, 1'b1, 32'hD0A0_0000);
    chk(got_ok, "R8 early accept with arm", {31'd0, got_ok}, 1);
    for (int c = 0; c < 24; c++) begin
      dma_ready = c[0];
      @(negedge clk);
    end
    dma_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(dn == 5, "R5 forwarded word count", 32'(dn), 5);
    for (int k = 0; k < 5; k++) begin
      chk(dq[k] == 32'hD0A0_0000 + 32'(k) && dl[k] == (k == 4),
          $sformatf("R5 forwarded word %0d", k), dq[k], 32'hD0A0_0000 + 32'(k));
    end
    chk(!dma_valid, "R5 drained", {31'd0, dma_valid}, 0);
    clear_status();

    // R4: overflow of a 20-word frame is an error
    send_frame(2, 20, 0, 0, 1'b0, 32'hE000_0000);
    chk(!got_ok && got_err, "R4 overflow refused", {30'd0, got_ok, got_err}, 1);
    chk(stat_err && !stat_ok, "R4 overflow error status", {30'd0, stat_err, stat_ok}, 2);
    clear_status();

    // R10: accept and reject together
    send_frame(2, 3, 0, 0, 1'b0, 32'hF000_0000);
    pulse_verdict(1'b1, 1'b1);
    chk(!got_ok && got_err, "R10 reject wins", {30'd0, got_ok, got_err}, 1);

    // R10: both pulsed early
    send_frame(2, 2, 0, 3, 1'b0, 32'hF100_0000);
    chk(!got_ok && got_err, "R10 reject wins early", {30'd0, got_ok, got_err}, 1);

    // R11: pulses when idle do nothing
    dn = 0;
    host_arm = 1'b1;
    pulse_verdict(1'b1, 1'b0);
    host_arm = 1'b0;
    chk(!got_ok && !got_err, "R11 idle verdict ignored", {30'd0, got_ok, got_err}, 0);
    repeat (3) @(negedge clk);
    chk(!ack_ok && !ack_err && !dma_valid && dn == 0, "R11 idle stays quiet",
        {29'd0, ack_ok, ack_err, dma_valid}, 0);
    clear_status();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule